// File: doc/BRIEF.md
# Predicated Vector Arithmetic Right Shifter

This block shifts each signed element of a packed vector to the right, with sign extension. The vector holds one operand to shift and one operand of shift counts. A 2-bit size code, set at runtime, picks the element width. A per-byte predicate chooses which elements take the shifted value. An element that is not chosen keeps its value from the first operand, so the result can be written back over that operand.

Each element's count is read as an unsigned number using all of its bits. The count saturates at the element width instead of wrapping, so a large count gives an element made only of sign bits. A wide-count mode takes each element's count from the whole 64-bit lane of the count vector that contains the element. This mode is defined only for 8-, 16- and 32-bit elements. If it is requested with 64-bit elements, the block raises a configuration-error output and passes the first operand through unchanged.

Results are registered, with one cycle of latency behind a valid strobe. The block produces no condition flags.

Top module: `vsar_top`

## Requirements
- R1: Every active element is shifted right by its effective count, and copies of its sign bit fill every vacated upper bit.
- R2: A count is an unsigned value over the whole count field. The effective shift is min(count, element width), so any count at or above the width gives all zeros for a non-negative element and all ones for a negative one.
- R3: The size code `size_sel` selects the element width: 2'b00 gives 8 bits, 2'b01 gives 16 bits, 2'b10 gives 32 bits and 2'b11 gives 64 bits. Element e occupies bits [e*W +: W].
- R4: `pred` has one bit per byte. Element e is active when `pred[e*W/8]`, the bit of its lowest byte, is 1. An inactive element takes its value from `src_a`, and the predicate bits of its other bytes have no effect.
- R5: When no element is active, `result` equals `src_a`.
- R6: With `wide_cnt` = 1 and 8-, 16- or 32-bit elements, the count of element e is the full 64-bit lane `src_b[(e*W/64)*64 +: 64]`.
- R7: With `wide_cnt` = 1 and `size_sel` = 2'b11, `cfg_err` is 1 for that result and `result` equals `src_a`. In every other accepted configuration, `cfg_err` is 0.
- R8: `out_valid` is `in_valid` delayed by one clock. `result` and `cfg_err` update only on a cycle where `in_valid` is 1, and hold their values otherwise.
- R9: While `rst_n` is low at a clock edge, `out_valid`, `cfg_err` and `result` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are present this cycle |
| size_sel | input | 2 | Element width code |
| wide_cnt | input | 1 | Take counts from the containing 64-bit lane |
| src_a | input | VW (128) | Elements to shift; also the value kept for inactive elements |
| src_b | input | VW (128) | Shift counts |
| pred | input | VW/8 (16) | Per-byte predicate |
| out_valid | output | 1 | Result register was loaded on the previous edge |
| result | output | VW (128) | Shifted and merged vector |
| cfg_err | output | 1 | Wide-count mode was requested with 64-bit elements |

## Verification
The assertions assume that `size_sel`, `wide_cnt` and the operands are at known values whenever `in_valid` is high. They also assume that the inputs are sampled at the rising edge, so that `$past` of the inputs describes the operation that loaded `result`. The stimulus keeps to this by changing every input only on falling edges and by driving all fields from defined values, including while idle. The random mix puts counts at 0, W-1, W, W+1 and all ones in every element or lane, so the saturation and sign-fill properties are exercised in each size.

// File: rtl/vsar_pkg.sv
// Package: shared element-size encoding for the vector shifter.
// Assumes a two-bit size code; width = 8 << code.
package vsar_pkg;
    typedef enum logic [1:0] {
        SZ_B8  = 2'b00,
        SZ_H16 = 2'b01,
        SZ_W32 = 2'b10,
        SZ_D64 = 2'b11
    } elem_size_e;

    localparam int unsigned NUM_SIZES = 4;
    localparam int unsigned LANE_W    = 64;
endpackage

// File: rtl/vsar_elem.sv
// Module: one element's saturating arithmetic right shift with predicate merge.
// Assumes the count arrives zero-extended to 64 bits; EW is a power of two <= 64.
module vsar_elem #(
    parameter int unsigned EW = 8
) (
    input  logic [EW-1:0] data_i,
    input  logic [63:0]   cnt_i,
    input  logic          act_i,
    output logic [EW-1:0] res_o
);
    localparam int unsigned SW = (EW > 1) ? $clog2(EW) : 1;

    logic          sat;
    logic [EW-1:0] shifted;

    // Saturate counts at or above the element width to a pure sign fill.
    always_comb begin
        sat     = (cnt_i >= 64'(EW));
        shifted = $signed(data_i) >>> cnt_i[SW-1:0];
        if (sat) begin
            shifted = {EW{data_i[EW-1]}};
        end
        res_o = act_i ? shifted : data_i;
    end
endmodule

// File: rtl/vsar_size_slice.sv
// Module: all elements of one element width across the vector.
// Assumes VW is a multiple of 64 and EW divides 64.
module vsar_size_slice #(
    parameter int unsigned VW = 128,
    parameter int unsigned EW = 8
) (
    input  logic [VW-1:0]   src_a_i,
    input  logic [VW-1:0]   src_b_i,
    input  logic [VW/8-1:0] pred_i,
    input  logic            wide_i,
    output logic [VW-1:0]   res_o
);
    localparam int unsigned NE = VW / EW;

    for (genvar e = 0; e < NE; e++) begin : g_elem
        localparam int unsigned LANE = (e * EW) / 64;
        localparam int unsigned PBIT = (e * EW) / 8;
        logic [63:0] cnt;

        // Pick the element's own count or its whole 64-bit lane.
        always_comb begin
            cnt = 64'(src_b_i[e*EW +: EW]);
            if (wide_i) begin
                cnt = src_b_i[LANE*64 +: 64];
            end
        end

        vsar_elem #(.EW(EW)) u_elem (
            .data_i (src_a_i[e*EW +: EW]),
            .cnt_i  (cnt),
            .act_i  (pred_i[PBIT]),
            .res_o  (res_o[e*EW +: EW])
        );
    end
endmodule

// File: rtl/vsar_top.sv
// Module: predicated vector arithmetic right shifter, registered output.
// Assumes inputs are stable around the rising edge; reset is synchronous active-low.
module vsar_top #(
    parameter int unsigned VW = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      size_sel,
    input  logic            wide_cnt,
    input  logic [VW-1:0]   src_a,
    input  logic [VW-1:0]   src_b,
    input  logic [VW/8-1:0] pred,
    output logic            out_valid,
    output logic [VW-1:0]   result,
    output logic            cfg_err
);
    import vsar_pkg::*;

    logic [VW-1:0] slice_res [NUM_SIZES];
    logic [VW-1:0] next_res;
    logic          illegal;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        vsar_size_slice #(.VW(VW), .EW(8 << s)) u_slice (
            .src_a_i (src_a),
            .src_b_i (src_b),
            .pred_i  (pred),
            .wide_i  (wide_cnt),
            .res_o   (slice_res[s])
        );
    end

    // Select the slice for the requested width; block the undefined combination.
    always_comb begin
        illegal  = wide_cnt && (elem_size_e'(size_sel) == SZ_D64);
        next_res = slice_res[size_sel];
        if (illegal) begin
            next_res = src_a;
        end
    end

    // Output register: load on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            cfg_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= next_res;
                cfg_err <= illegal;
            end
        end
    end
endmodule

// File: rtl/vsar_chk.sv
// Module: property checker for vsar_top, attached by bind.
// Assumes it sees the top's ports unchanged.
module vsar_chk #(
    parameter int unsigned VW = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      size_sel,
    input logic            wide_cnt,
    input logic [VW-1:0]   src_a,
    input logic [VW-1:0]   src_b,
    input logic [VW/8-1:0] pred,
    input logic            out_valid,
    input logic [VW-1:0]   result,
    input logic            cfg_err
);
    // R8: valid follows one cycle behind.
    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8: result holds while idle.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R1: sign bit of byte element 0 survives any shift.
    p_sign_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_sel == 2'b00) |=> result[7] == $past(src_a[7]));
    // R2: large count on an active 64-bit element gives pure sign fill.
    p_sat_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_sel == 2'b11 && !wide_cnt && pred[0] && src_b[63:0] >= 64'd64)
        |=> result[63:0] == {64{$past(src_a[63])}});
    // R4: inactive element 0 keeps its low byte.
    p_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pred[0]) |=> result[7:0] == $past(src_a[7:0]));
    // R5: empty predicate passes src_a.
    p_none_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred == '0) |=> result == $past(src_a));
    // R6: wide lane count at or above 32 sign-fills word element 0.
    p_wide_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_sel == 2'b10 && wide_cnt && pred[0] && src_b[63:0] >= 64'd32)
        |=> result[31:0] == {32{$past(src_a[31])}});
    // R7: illegal configuration flagged and passed through.
    p_cfg_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_cnt && size_sel == 2'b11) |=> (cfg_err && result == $past(src_a)));
    p_cfg_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(wide_cnt && size_sel == 2'b11)) |=> !cfg_err);
endmodule

bind vsar_top vsar_chk #(.VW(VW)) u_vsar_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .size_sel  (size_sel),
    .wide_cnt  (wide_cnt),
    .src_a     (src_a),
    .src_b     (src_b),
    .pred      (pred),
    .out_valid (out_valid),
    .result    (result),
    .cfg_err   (cfg_err)
);

// File: tb/vsar_top_tb_top.sv
// Bench: directed corners plus seeded random vectors against a reference function.
module vsar_top_tb_top;
    localparam int unsigned VW = 128;
    localparam int unsigned PW = VW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    size_sel = 2'b00;
    logic          wide_cnt = 1'b0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic [PW-1:0] pred = '0;
    logic          out_valid;
    logic [VW-1:0] result;
    logic          cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vsar_top #(.VW(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
        .wide_cnt(wide_cnt), .src_a(src_a), .src_b(src_b), .pred(pred),
        .out_valid(out_valid), .result(result), .cfg_err(cfg_err)
    );

    // Reference: expected vector from the requirements.
    function automatic logic [VW-1:0] ref_model(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                                 input logic [PW-1:0] p, input logic [1:0] sz,
                                                 input logic wide);
        logic [VW-1:0] r;
        int ew;
        r  = a;
        ew = 8 << sz;
        if (wide && sz == 2'b11) return a;
        for (int e = 0; e < VW / ew; e++) begin
            logic [63:0] elem, cnt, mask, shv;
            int sh;
            mask = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
            elem = 64'(a >> (e * ew)) & mask;
            if (elem[ew-1]) elem = elem | ~mask;
            cnt = wide ? 64'(b >> ((e * ew / 64) * 64)) : (64'(b >> (e * ew)) & mask);
            sh  = (cnt >= 64'(ew)) ? 63 : int'(cnt);
            shv = $signed(elem) >>> sh;
            if (p[e * ew / 8]) begin
                for (int k = 0; k < ew; k++) r[e * ew + k] = shv[k];
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Fill every element (or 64-bit lane when wide) of the count vector with one value.
    function automatic logic [VW-1:0] fill_cnt(input logic [63:0] c, input int ew);
        logic [VW-1:0] v;
        v = '0;
        for (int e = 0; e < VW / ew; e++)
            for (int k = 0; k < ew; k++) v[e * ew + k] = c[k];
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operation at a falling edge; check at the next falling edge.
    task automatic apply(input logic [1:0] sz, input logic wide, input logic [VW-1:0] a,
                         input logic [VW-1:0] b, input logic [PW-1:0] p, input string req);
        logic [VW-1:0] exp;
        bit ill;
        exp = ref_model(a, b, p, sz, wide);
        ill = wide && (sz == 2'b11);
        size_sel = sz; wide_cnt = wide; src_a = a; src_b = b; pred = p; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(result == exp, req, result, exp);
        chk(cfg_err == ill, {req, " R7 cfg_err"}, VW'(cfg_err), VW'(ill));
        chk(out_valid == 1'b1, {req, " R8 out_valid"}, VW'(out_valid), VW'(1));
    endtask

    initial begin
        logic [VW-1:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state.
        chk(out_valid == 1'b0, "R9 out_valid", VW'(out_valid), '0);
        chk(cfg_err == 1'b0, "R9 cfg_err", VW'(cfg_err), '0);
        chk(result == '0, "R9 result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3: each size with corner counts, all elements active and random predicate.
        for (int s = 0; s < 4; s++) begin
            int ew;
            logic [63:0] cl [5];
            ew = 8 << s;
            cl[0] = 64'd0; cl[1] = 64'(ew - 1); cl[2] = 64'(ew); cl[3] = 64'(ew + 1); cl[4] = '1;
            for (int c = 0; c < 5; c++) begin
                apply(2'(s), 1'b0, rand_vec(), fill_cnt(cl[c], ew), '1, "R1 R2 R3 all-active");
                apply(2'(s), 1'b0, rand_vec(), fill_cnt(cl[c], ew), PW'(rand_vec()), "R4 random pred");
            end
        end
        // R2: negative and non-negative elements at saturation.
        apply(2'b01, 1'b0, {8{16'h8001}}, fill_cnt(64'd200, 16), '1, "R2 negative sat");
        apply(2'b01, 1'b0, {8{16'h7FFF}}, fill_cnt(64'd16, 16), '1, "R2 positive sat");
        // R4: only non-lowest bytes of word elements set.
        apply(2'b10, 1'b0, rand_vec(), fill_cnt(64'd3, 32), 16'hEEEE, "R4 upper bytes ignored");
        // R5: nothing active.
        apply(2'b00, 1'b0, rand_vec(), rand_vec(), '0, "R5 no active");
        // R6: wide counts per size with lane corner counts.
        for (int s = 0; s < 3; s++) begin
            int ew;
            ew = 8 << s;
            apply(2'(s), 1'b1, rand_vec(), {64'd3, 64'd0}, '1, "R6 small lane counts");
            apply(2'(s), 1'b1, rand_vec(), {64'(ew), 64'(ew - 1)}, '1, "R6 lane at width");
            apply(2'(s), 1'b1, rand_vec(), {64'h1_0000_0000, 64'd1}, '1, "R6 upper lane bits count");
        end
        // R7: illegal combination.
        apply(2'b11, 1'b1, rand_vec(), fill_cnt(64'd4, 64), '1, "R7 illegal");
        apply(2'b11, 1'b0, rand_vec(), fill_cnt(64'd4, 64), '1, "R7 legal after illegal");
        // R8: hold while idle with changing inputs.
        held = result;
        src_a = rand_vec(); src_b = rand_vec(); pred = '1; size_sel = 2'b00; wide_cnt = 1'b1;
        @(negedge clk);
        chk(result == held, "R8 hold result", result, held);
        chk(out_valid == 1'b0, "R8 idle out_valid", VW'(out_valid), '0);

        // Random mix with corner-biased counts.
        for (int i = 0; i < 2000; i++) begin
            logic [1:0] sz;
            logic wide;
            int ew, pick;
            logic [VW-1:0] b;
            sz   = 2'($urandom_range(0, 3));
            wide = ($urandom_range(0, 3) == 0);
            ew   = wide ? 64 : (8 << sz);
            pick = $urandom_range(0, 5);
            case (pick)
                0: b = fill_cnt(64'd0, ew);
                1: b = fill_cnt(64'((8 << sz) - 1), ew);
                2: b = fill_cnt(64'(8 << sz), ew);
                3: b = fill_cnt(64'((8 << sz) + 1), ew);
                4: b = '1;
                default: b = rand_vec() & {16{8'h0F}};
            endcase
            apply(sz, wide, rand_vec(), b, PW'(rand_vec()), "R1 R4 R6 random");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule